// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned operands of `W` bits each and returns the full `2W`-bit product. It takes one clock for each multiplier bit. The design keeps only one double-width register. The multiplier is loaded into its lower half, and the upper half starts at zero and collects partial sums. In each step, the low bit of that register decides whether the stored multiplicand is added into the upper half. The register then moves right by one place, and the adder's carry enters at the top.

A request is offered with `in_valid` and the two operands. It is taken on a clock edge where `in_ready` is also high. `in_ready` is low for the whole computation, so a request offered then is not taken and leaves the running job untouched. The result has no back-pressure: `done` pulses for one cycle, and `product` keeps the answer until the next request is taken.

Top module: `mul_shift_add`

## Requirements
- R1: While `rst` is high at a clock edge, the block is cleared: after that edge `busy` and `done` are 0, `in_ready` is 1 and `product` is 0.
- R2: `in_ready` is always the inverse of `busy`. A request is taken only on an edge where `in_valid` and `in_ready` are both 1.
- R3: After the edge that takes a request, `busy` is 1 for exactly `W` cycles and then returns to 0.
- R4: `done` is 1 for exactly one cycle, which is the first cycle in which `busy` is 0 again after a computation.
- R5: While `done` is 1, `product` equals the unsigned product of `op_a` and `op_b` as sampled when the request was taken. This includes zero operands and all-ones operands, where the carry out of the adder reaches the top bit.
- R6: Requests offered while `busy` is 1 are ignored. The running result still matches the operands that were taken.
- R7: After `done`, `product` keeps its value until the next request is taken.
- R8: In the cycle after a request is taken, `product` shows the loaded register: upper `W` bits zero, lower `W` bits equal to `op_b`.
- R9: With `W` = 4, operands 12 (multiplicand) and 13 (multiplier) give 156 (binary 10011100).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A request with operands is offered |
| in_ready | output | 1 | Block can take a request (idle) |
| op_a | input | W | Multiplicand, unsigned |
| op_b | input | W | Multiplier, unsigned |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| product | output | 2W | Product register contents |

## Verification
The bench builds two copies of the block, one with `W` = 32 and one with `W` = 4. The 32-bit copy exercises the full 32-step count, the cycle-exact position of `done`, and the all-ones case, where every step adds and the carry must be shifted back in. The 4-bit copy makes the small worked case (12 × 13) visible step for step and checks it against the known answer of 156. Both copies are compared with the bench's own multiplication.

// File: rtl/mul_sa_pkg.sv
package mul_sa_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mul_state_e;
endpackage

// File: rtl/mul_sa_adder.sv
module mul_sa_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] acc,
  input  logic [W-1:0] addend,
  input  logic         add_en,
  output logic [W:0]   sum
);
  logic [W-1:0] gated;

  always_comb begin
    gated = add_en ? addend : '0;
    sum   = {1'b0, acc} + {1'b0, gated};
  end
endmodule

// File: rtl/mul_sa_ctrl.sv
module mul_sa_ctrl #(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic take,
  output logic step,
  output logic busy,
  output logic done
);
  import mul_sa_pkg::*;

  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  mul_state_e    state;
  logic [CW-1:0] iter;

  assign busy = (state == ST_RUN);
  assign step = busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      iter  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (take) begin
            state <= ST_RUN;
            iter  <= '0;
          end
        end
        ST_RUN: begin
          if (iter == LAST) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            iter <= iter + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mul_sa_datapath.sv
module mul_sa_datapath #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           step,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic [2*W-1:0] prod_q
);
  logic [W-1:0] mcand_q;
  logic [W:0]   sum;

  mul_sa_adder #(.W(W)) u_adder (
    .acc    (prod_q[2*W-1:W]),
    .addend (mcand_q),
    .add_en (prod_q[0]),
    .sum    (sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_q  <= '0;
      mcand_q <= '0;
    end else if (load) begin
      prod_q  <= {{W{1'b0}}, op_b};
      mcand_q <= op_a;
    end else if (step) begin
      prod_q <= {sum, prod_q[W-1:1]};
    end
  end
endmodule

// File: rtl/mul_shift_add.sv
module mul_shift_add #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic           busy,
  output logic           done,
  output logic [2*W-1:0] product
);
  logic take;
  logic step;
  logic busy_i;

  assign in_ready = ~busy_i;
  assign take     = in_valid & ~busy_i;
  assign busy     = busy_i;

  mul_sa_ctrl #(.W(W)) u_ctrl (
    .clk  (clk),
    .rst  (rst),
    .take (take),
    .step (step),
    .busy (busy_i),
    .done (done)
  );

  mul_sa_datapath #(.W(W)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .load   (take),
    .step   (step),
    .op_a   (op_a),
    .op_b   (op_b),
    .prod_q (product)
  );
endmodule

// File: rtl/mul_shift_add_chk.sv
module mul_shift_add_chk #(
  parameter int W = 32
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic           in_ready,
  input logic [W-1:0]   op_a,
  input logic [W-1:0]   op_b,
  input logic           busy,
  input logic           done,
  input logic [2*W-1:0] product
);
  localparam int KW = $clog2(W + 1) + 1;

  logic [KW-1:0]  run_cnt;
  logic [2*W-1:0] exp_prod;
  logic           accepted;

  assign accepted = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt  <= '0;
      exp_prod <= '0;
    end else if (accepted) begin
      run_cnt  <= '0;
      exp_prod <= {{W{1'b0}}, op_a} * {{W{1'b0}}, op_b};
    end else if (busy) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  a_r2_ready_vs_busy: assert property (@(posedge clk) disable iff (rst)
    in_ready == !busy);

  a_r3_busy_after_take: assert property (@(posedge clk) disable iff (rst)
    accepted |=> busy);

  a_r3_busy_window: assert property (@(posedge clk) disable iff (rst)
    busy |-> run_cnt < KW'(W));

  a_r4_done_at_count: assert property (@(posedge clk) disable iff (rst)
    done |-> (run_cnt == KW'(W)) && !busy);

  a_r4_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r5_result: assert property (@(posedge clk) disable iff (rst)
    done |-> product == exp_prod);

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy && !accepted) |=> $stable(product));

  a_r8_load: assert property (@(posedge clk) disable iff (rst)
    accepted |=> product == {{W{1'b0}}, $past(op_b)});
endmodule

bind mul_shift_add mul_shift_add_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .op_a     (op_a),
  .op_b     (op_b),
  .busy     (busy),
  .done     (done),
  .product  (product)
);

// File: tb/mul_shift_add_tb.sv
module mul_shift_add_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 32;
  localparam int W4 = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  logic           v32 = 1'b0;
  logic           rdy32, busy32, done32;
  logic [W-1:0]   a32 = '0, b32 = '0;
  logic [2*W-1:0] p32;

  logic            v4 = 1'b0;
  logic            rdy4, busy4, done4;
  logic [W4-1:0]   a4 = '0, b4 = '0;
  logic [2*W4-1:0] p4;

  mul_shift_add #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .in_valid(v32), .in_ready(rdy32),
    .op_a(a32), .op_b(b32), .busy(busy32), .done(done32), .product(p32)
  );

  mul_shift_add #(.W(W4)) u_dut_w4 (
    .clk(clk), .rst(rst), .in_valid(v4), .in_ready(rdy4),
    .op_a(a4), .op_b(b4), .busy(busy4), .done(done4), .product(p4)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drives one request on the 32-bit copy; optionally offers a second
  // request while busy. Checks load, busy span, done pulse, result, hold.
  task automatic run32(input logic [W-1:0] a, input logic [W-1:0] b,
                       input bit poke);
    logic [2*W-1:0] exp;
    int cyc;
    exp = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    @(negedge clk);
    v32 = 1'b1; a32 = a; b32 = b;
    @(negedge clk);
    v32 = 1'b0; a32 = ~a; b32 = ~b;
    chk(p32 == {{W{1'b0}}, b}, "R8 load", p32, {{W{1'b0}}, b});
    chk(busy32 && !rdy32, "R2 busy/ready", {62'd0, busy32, rdy32}, 64'd2);
    cyc = 1;
    while (!done32 && cyc < 100) begin
      if (poke && cyc == 5) v32 = 1'b1;
      @(negedge clk);
      v32 = 1'b0;
      cyc++;
    end
    chk(cyc == W + 1, "R3 busy span", 64'(cyc), 64'(W + 1));
    chk(done32 && !busy32, "R4 done with idle", {62'd0, done32, busy32}, 64'd2);
    chk(p32 == exp, poke ? "R6 ignored request" : "R5 product", p32, exp);
    @(negedge clk);
    chk(!done32, "R4 single pulse", 64'(done32), 64'd0);
    repeat (4) @(negedge clk);
    chk(p32 == exp, "R7 hold", p32, exp);
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk(!busy32 && !done32 && rdy32 && p32 == '0, "R1 reset",
        {61'd0, busy32, done32, rdy32}, 64'd1);
    chk(!busy4 && !done4 && rdy4 && p4 == '0, "R1 reset w4",
        {61'd0, busy4, done4, rdy4}, 64'd1);
  endtask

  task automatic test_w4();
    int cyc;
    @(negedge clk);
    v4 = 1'b1; a4 = 4'b1100; b4 = 4'b1101;
    @(negedge clk);
    v4 = 1'b0;
    chk(p4 == 8'b0000_1101, "R8 load w4", 64'(p4), 64'h0d);
    cyc = 1;
    while (!done4 && cyc < 20) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc == W4 + 1, "R3 busy span w4", 64'(cyc), 64'(W4 + 1));
    chk(p4 == 8'd156, "R9 worked case", 64'(p4), 64'd156);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    test_reset();
    run32(32'd7, 32'd9, 1'b0);
    run32(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    run32(32'h0, 32'hDEAD_BEEF, 1'b0);
    run32(32'h1234_5678, 32'h0, 1'b0);
    run32(32'h8000_0001, 32'hA5A5_5A5A, 1'b1);
    test_w4();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule